// File: doc/BRIEF.md
# Shared Data-Pin and Flag-Pin Function Router

This block decides which on-chip function owns each of the 32 shared external data pins and each of four dedicated flag pins. The data pins are split into eight groups of four. Each group belongs to exactly one of these: external memory, the parallel acquisition port, a PWM output group, a memory-to-memory data group, or a general-purpose flag group. A fixed priority settles any clash between them. For every pin the block drives the output value and the output enable, and it steers the pin inputs back to the function that owns the pin. The flag pins can each work as a core flag. Pins 0 to 2 can instead become interrupt request inputs, and pin 3 can instead carry the timer expiry signal.

Two 32-bit registers hold the routing: a system routing register and an acquisition control register. A simple write/select port loads them, and the same port reads them back. Software first selects a mapping. The pads then follow it from the cycle after the write.

All pad-side and function-side outputs are registered once. A change on any input or in the configuration shows at the outputs one clock edge later.

Top module: `pinmux_top`

## Requirements
- R1: A synchronous reset clears both registers and every registered output. After reset, every data group is in external-memory mode and every flag pin is in core-flag mode.
- R2: A write with `cfg_sel`=0 loads the system routing register, and a write with `cfg_sel`=1 loads the acquisition control register. The new value governs routing from the next edge. `cfg_rdata` shows the raw stored value of the register that `cfg_sel` picked one cycle earlier, and it shows the value from before any write in that same cycle.
- R3: The acquisition port takes the data pins only when system bit 0 is set, acquisition control bit 26 (pin source) is set, and acquisition control bit 31 (port enable) is set. Bit 26 is stored and read back without change, whatever the state of bit 31.
- R4: While the acquisition port has the pins, `acq_data` is pins 31..12, `acq_ctl` is pins 11..8, and pins 31..8 have their output enable low. Otherwise `acq_data` follows `sai_di` and `acq_ctl` is zero.
- R5: System bits 15..8 hold one PWM bit per data group, with bit 8+g for group g. Only groups 4..7 honour the bit. Group pin k then drives `pwm_out[k]` with the enable high.
- R6: System bits 23..16 hold one memory-to-memory bit per group, with bit 16+g for group g. Only groups 4..7 honour the bit. Such a group drives `mtm_do` with all enables equal to `mtm_oe`. `mtm_di` comes from the lowest-numbered group in this mode, and it is zero if there is none.
- R7: System bits 31..24 hold one general-purpose flag bit per group, with bit 24+g for group g. Any group honours the bit. Pin k drives `gpf_do[k]` with enable `gpf_oe[k]`. `gpf_di` comes from the lowest such group, and it is zero if there is none.
- R8: When several modes claim one group, the order of precedence is acquisition port, PWM, memory-to-memory, flags, and then external memory.
- R9: A pin in external-memory mode drives `mem_do` of its index with enable `mem_oe`, and the pin's input appears on `mem_di`. `mem_di` is zero for every pin in any other mode.
- R10: System bit 1+i (i = 0..2) puts flag pin i into interrupt mode. In that mode the pin enable and output are low, `irq_req[i]` follows the pin, and `cflag_di[i]` is zero. When the bit is clear, the pin drives `cflag_do`/`cflag_oe`, the pin's input appears on `cflag_di`, and `irq_req[i]` is zero.
- R11: System bit 4 makes flag pin 3 drive `tmr_exp` with its enable high, and `cflag_di[3]` is then zero. When the bit is clear, pin 3 is a core flag.
- R12: Every output reflects the register contents and inputs sampled at the previous rising edge. The delay is exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 system routing, 1 acquisition control |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered readback of the selected register |
| pad_di | input | 32 | Data pin input values |
| pad_do | output | 32 | Data pin output values |
| pad_oe | output | 32 | Data pin output enables |
| mem_do | input | 32 | External memory write data |
| mem_oe | input | 1 | External memory drive enable |
| mem_di | output | 32 | External memory read data |
| pwm_out | input | 4 | PWM outputs placed on a group |
| mtm_do | input | 4 | Memory-to-memory output data |
| mtm_oe | input | 1 | Memory-to-memory drive enable |
| mtm_di | output | 4 | Memory-to-memory input data |
| gpf_do | input | 4 | General-purpose flag outputs |
| gpf_oe | input | 4 | General-purpose flag enables, one per bit |
| gpf_di | output | 4 | General-purpose flag inputs |
| sai_di | input | 20 | Serial audio pins used as the alternative acquisition source |
| acq_data | output | 20 | Acquisition port data |
| acq_ctl | output | 4 | Acquisition port control strobes |
| fpin_di | input | 4 | Flag pin inputs |
| fpin_do | output | 4 | Flag pin outputs |
| fpin_oe | output | 4 | Flag pin output enables |
| cflag_do | input | 4 | Core flag output values |
| cflag_oe | input | 4 | Core flag output enables |
| cflag_di | output | 4 | Core flag input values |
| irq_req | output | 3 | Interrupt requests from flag pins 0..2 |
| tmr_exp | input | 1 | Timer expiry signal |

## Verification
The assertions check several rules on every cycle:
- No lower group is ever decoded as PWM or memory-to-memory.
- A group owned by the acquisition port has its enables low one cycle later.
- An external-memory group copies `mem_oe` onto its enables.
- Interrupt-mode and timer-mode flag pins behave as specified.
- The registers clear on reset and load on write.

Only the bench's scenarios can show the following:
- The full precedence between overlapping masks.
- The lowest-group rule for the grouped inputs.
- The three-way gating of the acquisition source.
- That illegal lower-group bits are stored but have no effect.

The bench shows these by comparing every output against a behavioural model under directed and random register contents.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

  typedef enum logic [2:0] {
    FN_MEM = 3'd0,
    FN_GPF = 3'd1,
    FN_MTM = 3'd2,
    FN_PWM = 3'd3,
    FN_ACQ = 3'd4
  } pin_fn_e;

  localparam int REG_W       = 32;
  // system routing register fields
  localparam int SC_ACQ_BIT  = 0;
  localparam int SC_IRQ_LO   = 1;
  localparam int SC_TMR_BIT  = 4;
  localparam int SC_PWM_LO   = 8;
  localparam int SC_MTM_LO   = 16;
  localparam int SC_GPF_LO   = 24;
  // acquisition control register fields
  localparam int AC_SEL_BIT  = 26;
  localparam int AC_EN_BIT   = 31;

endpackage

// File: rtl/pinmux_cfg_regs.sv
module pinmux_cfg_regs
  import pinmux_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic             cfg_sel,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] sys_q,
  output logic [REG_W-1:0] acq_q,
  output logic [REG_W-1:0] cfg_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_q     <= '0;
      acq_q     <= '0;
      cfg_rdata <= '0;
    end else begin
      if (cfg_wr && !cfg_sel) sys_q <= cfg_wdata;
      if (cfg_wr &&  cfg_sel) acq_q <= cfg_wdata;
      cfg_rdata <= cfg_sel ? acq_q : sys_q;
    end
  end

  // R1
  reset_default_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sys_q == '0 && acq_q == '0));

  // R2
  sysctl_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && !cfg_sel) |=> (sys_q == $past(cfg_wdata)));

  // R2
  acqctl_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr && cfg_sel) |=> (acq_q == $past(cfg_wdata)));

endmodule

// File: rtl/pinmux_grp_arb.sv
module pinmux_grp_arb
  import pinmux_pkg::*;
#(
  parameter int NGRP       = 8,
  parameter int UPPER_LO   = 4,
  parameter int ACQ_LO_GRP = 2
) (
  input  logic [REG_W-1:0]        sys_q,
  input  logic [REG_W-1:0]        acq_q,
  output logic                    acq_take,
  output pin_fn_e [NGRP-1:0]      grp_fn
);

  logic acq_src_eff;

  // pin-source select only counts while the port is enabled
  assign acq_src_eff = acq_q[AC_SEL_BIT] & acq_q[AC_EN_BIT];
  assign acq_take    = sys_q[SC_ACQ_BIT] & acq_src_eff;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam bit UPPER  = (g >= UPPER_LO);
    localparam bit ACQ_OK = (g >= ACQ_LO_GRP);
    pin_fn_e fn_g;

    always_comb begin
      if (ACQ_OK && acq_take)                      fn_g = FN_ACQ;
      else if (UPPER && sys_q[SC_PWM_LO + g])      fn_g = FN_PWM;
      else if (UPPER && sys_q[SC_MTM_LO + g])      fn_g = FN_MTM;
      else if (sys_q[SC_GPF_LO + g])               fn_g = FN_GPF;
      else                                         fn_g = FN_MEM;
    end

    assign grp_fn[g] = fn_g;
  end

endmodule

// File: rtl/pinmux_data_route.sv
module pinmux_data_route
  import pinmux_pkg::*;
#(
  parameter int DW         = 32,
  parameter int GW         = 4,
  parameter int ACQ_DW     = 20,
  parameter int ACQ_CW     = 4,
  parameter int UPPER_LO   = 4,
  parameter int ACQ_LO_GRP = 2,
  localparam int NGRP      = DW / GW
) (
  input  logic               clk,
  input  logic               rst,
  input  pin_fn_e [NGRP-1:0] grp_fn,
  input  logic               acq_take,
  input  logic [DW-1:0]      pad_di,
  input  logic [DW-1:0]      mem_do,
  input  logic               mem_oe,
  input  logic [GW-1:0]      pwm_out,
  input  logic [GW-1:0]      mtm_do,
  input  logic               mtm_oe,
  input  logic [GW-1:0]      gpf_do,
  input  logic [GW-1:0]      gpf_oe,
  input  logic [ACQ_DW-1:0]  sai_di,
  output logic [DW-1:0]      pad_do,
  output logic [DW-1:0]      pad_oe,
  output logic [DW-1:0]      mem_di,
  output logic [GW-1:0]      mtm_di,
  output logic [GW-1:0]      gpf_di,
  output logic [ACQ_DW-1:0]  acq_data,
  output logic [ACQ_CW-1:0]  acq_ctl
);

  logic [DW-1:0]     do_n, oe_n, mdi_n;
  logic [GW-1:0]     mtm_n, gpf_n;
  logic [ACQ_DW-1:0] acqd_n;
  logic [ACQ_CW-1:0] acqc_n;

  always_comb begin
    do_n  = '0;
    oe_n  = '0;
    mdi_n = '0;
    for (int g = 0; g < NGRP; g++) begin
      for (int k = 0; k < GW; k++) begin
        case (grp_fn[g])
          FN_PWM: begin
            do_n[g*GW + k] = pwm_out[k];
            oe_n[g*GW + k] = 1'b1;
          end
          FN_MTM: begin
            do_n[g*GW + k] = mtm_do[k];
            oe_n[g*GW + k] = mtm_oe;
          end
          FN_GPF: begin
            do_n[g*GW + k] = gpf_do[k];
            oe_n[g*GW + k] = gpf_oe[k];
          end
          FN_MEM: begin
            do_n[g*GW + k]  = mem_do[g*GW + k];
            oe_n[g*GW + k]  = mem_oe;
            mdi_n[g*GW + k] = pad_di[g*GW + k];
          end
          default: begin
            do_n[g*GW + k] = 1'b0;
            oe_n[g*GW + k] = 1'b0;
          end
        endcase
      end
    end
  end

  // grouped inputs: lowest-numbered owning group wins
  always_comb begin
    mtm_n = '0;
    gpf_n = '0;
    for (int g = NGRP - 1; g >= 0; g--) begin
      if (grp_fn[g] == FN_MTM) mtm_n = pad_di[g*GW +: GW];
      if (grp_fn[g] == FN_GPF) gpf_n = pad_di[g*GW +: GW];
    end
  end

  always_comb begin
    if (acq_take) begin
      acqd_n = pad_di[DW-1 -: ACQ_DW];
      acqc_n = pad_di[DW-ACQ_DW-1 -: ACQ_CW];
    end else begin
      acqd_n = sai_di;
      acqc_n = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_do   <= '0;
      pad_oe   <= '0;
      mem_di   <= '0;
      mtm_di   <= '0;
      gpf_di   <= '0;
      acq_data <= '0;
      acq_ctl  <= '0;
    end else begin
      pad_do   <= do_n;
      pad_oe   <= oe_n;
      mem_di   <= mdi_n;
      mtm_di   <= mtm_n;
      gpf_di   <= gpf_n;
      acq_data <= acqd_n;
      acq_ctl  <= acqc_n;
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_chk
    if (g < UPPER_LO) begin : g_low
      // R5
      no_low_pwm_chk: assert property (@(posedge clk) disable iff (rst)
        grp_fn[g] != FN_PWM);
      // R6
      no_low_mtm_chk: assert property (@(posedge clk) disable iff (rst)
        grp_fn[g] != FN_MTM);
    end
    if (g >= ACQ_LO_GRP) begin : g_acq
      // R4
      acq_oe_low_chk: assert property (@(posedge clk) disable iff (rst)
        (grp_fn[g] == FN_ACQ) |=> (pad_oe[g*GW +: GW] == '0));
    end
    // R9
    mem_oe_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (grp_fn[g] == FN_MEM) |=> (pad_oe[g*GW +: GW] == {GW{$past(mem_oe)}}));
  end

endmodule

// File: rtl/pinmux_flag_route.sv
module pinmux_flag_route #(
  parameter int NFLAG = 4,
  parameter int NIRQ  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NIRQ-1:0]  irq_mode,
  input  logic             tmr_mode,
  input  logic [NFLAG-1:0] fpin_di,
  input  logic [NFLAG-1:0] cflag_do,
  input  logic [NFLAG-1:0] cflag_oe,
  input  logic             tmr_exp,
  output logic [NFLAG-1:0] fpin_do,
  output logic [NFLAG-1:0] fpin_oe,
  output logic [NFLAG-1:0] cflag_di,
  output logic [NIRQ-1:0]  irq_req
);

  for (genvar i = 0; i < NFLAG; i++) begin : g_pin
    logic do_q, oe_q, cf_q;

    if (i < NIRQ) begin : g_irq
      logic iq_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          do_q <= 1'b0; oe_q <= 1'b0; cf_q <= 1'b0; iq_q <= 1'b0;
        end else if (irq_mode[i]) begin
          do_q <= 1'b0; oe_q <= 1'b0; cf_q <= 1'b0; iq_q <= fpin_di[i];
        end else begin
          do_q <= cflag_do[i]; oe_q <= cflag_oe[i]; cf_q <= fpin_di[i]; iq_q <= 1'b0;
        end
      end
      assign irq_req[i] = iq_q;

      // R10
      irq_pin_chk: assert property (@(posedge clk) disable iff (rst)
        irq_mode[i] |=> (!fpin_oe[i] && irq_req[i] == $past(fpin_di[i])));
    end else if (i == NFLAG - 1) begin : g_tmr
      always_ff @(posedge clk) begin
        if (rst) begin
          do_q <= 1'b0; oe_q <= 1'b0; cf_q <= 1'b0;
        end else if (tmr_mode) begin
          do_q <= tmr_exp; oe_q <= 1'b1; cf_q <= 1'b0;
        end else begin
          do_q <= cflag_do[i]; oe_q <= cflag_oe[i]; cf_q <= fpin_di[i];
        end
      end

      // R11
      tmr_drive_chk: assert property (@(posedge clk) disable iff (rst)
        tmr_mode |=> (fpin_oe[i] && fpin_do[i] == $past(tmr_exp)));
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst) begin
          do_q <= 1'b0; oe_q <= 1'b0; cf_q <= 1'b0;
        end else begin
          do_q <= cflag_do[i]; oe_q <= cflag_oe[i]; cf_q <= fpin_di[i];
        end
      end
    end

    assign fpin_do[i]  = do_q;
    assign fpin_oe[i]  = oe_q;
    assign cflag_di[i] = cf_q;
  end

endmodule

// File: rtl/pinmux_top.sv
module pinmux_top
  import pinmux_pkg::*;
#(
  parameter int DW     = 32,
  parameter int GW     = 4,
  parameter int ACQ_DW = 20,
  parameter int ACQ_CW = 4,
  parameter int NFLAG  = 4,
  parameter int NIRQ   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [DW-1:0]     pad_di,
  output logic [DW-1:0]     pad_do,
  output logic [DW-1:0]     pad_oe,
  input  logic [DW-1:0]     mem_do,
  input  logic              mem_oe,
  output logic [DW-1:0]     mem_di,
  input  logic [GW-1:0]     pwm_out,
  input  logic [GW-1:0]     mtm_do,
  input  logic              mtm_oe,
  output logic [GW-1:0]     mtm_di,
  input  logic [GW-1:0]     gpf_do,
  input  logic [GW-1:0]     gpf_oe,
  output logic [GW-1:0]     gpf_di,
  input  logic [ACQ_DW-1:0] sai_di,
  output logic [ACQ_DW-1:0] acq_data,
  output logic [ACQ_CW-1:0] acq_ctl,
  input  logic [NFLAG-1:0]  fpin_di,
  output logic [NFLAG-1:0]  fpin_do,
  output logic [NFLAG-1:0]  fpin_oe,
  input  logic [NFLAG-1:0]  cflag_do,
  input  logic [NFLAG-1:0]  cflag_oe,
  output logic [NFLAG-1:0]  cflag_di,
  output logic [NIRQ-1:0]   irq_req,
  input  logic              tmr_exp
);

  localparam int NGRP       = DW / GW;
  localparam int UPPER_LO   = NGRP / 2;
  localparam int ACQ_LO_GRP = (DW - ACQ_DW - ACQ_CW) / GW;

  logic [REG_W-1:0]   sys_q, acq_q;
  logic               acq_take;
  pin_fn_e [NGRP-1:0] grp_fn;

  pinmux_cfg_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_sel   (cfg_sel),
    .cfg_wdata (cfg_wdata),
    .sys_q     (sys_q),
    .acq_q     (acq_q),
    .cfg_rdata (cfg_rdata)
  );

  pinmux_grp_arb #(
    .NGRP       (NGRP),
    .UPPER_LO   (UPPER_LO),
    .ACQ_LO_GRP (ACQ_LO_GRP)
  ) u_arb (
    .sys_q    (sys_q),
    .acq_q    (acq_q),
    .acq_take (acq_take),
    .grp_fn   (grp_fn)
  );

  pinmux_data_route #(
    .DW         (DW),
    .GW         (GW),
    .ACQ_DW     (ACQ_DW),
    .ACQ_CW     (ACQ_CW),
    .UPPER_LO   (UPPER_LO),
    .ACQ_LO_GRP (ACQ_LO_GRP)
  ) u_route (
    .clk      (clk),
    .rst      (rst),
    .grp_fn   (grp_fn),
    .acq_take (acq_take),
    .pad_di   (pad_di),
    .mem_do   (mem_do),
    .mem_oe   (mem_oe),
    .pwm_out  (pwm_out),
    .mtm_do   (mtm_do),
    .mtm_oe   (mtm_oe),
    .gpf_do   (gpf_do),
    .gpf_oe   (gpf_oe),
    .sai_di   (sai_di),
    .pad_do   (pad_do),
    .pad_oe   (pad_oe),
    .mem_di   (mem_di),
    .mtm_di   (mtm_di),
    .gpf_di   (gpf_di),
    .acq_data (acq_data),
    .acq_ctl  (acq_ctl)
  );

  pinmux_flag_route #(
    .NFLAG (NFLAG),
    .NIRQ  (NIRQ)
  ) u_flag (
    .clk      (clk),
    .rst      (rst),
    .irq_mode (sys_q[SC_IRQ_LO +: NIRQ]),
    .tmr_mode (sys_q[SC_TMR_BIT]),
    .fpin_di  (fpin_di),
    .cflag_do (cflag_do),
    .cflag_oe (cflag_oe),
    .tmr_exp  (tmr_exp),
    .fpin_do  (fpin_do),
    .fpin_oe  (fpin_oe),
    .cflag_di (cflag_di),
    .irq_req  (irq_req)
  );

endmodule

// File: tb/sim_pinmux_top.sv
module sim_pinmux_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0, cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic [31:0] pad_di = '0, pad_do, pad_oe, mem_do = '0, mem_di;
  logic        mem_oe = 1'b0, mtm_oe = 1'b0, tmr_exp = 1'b0;
  logic [3:0]  pwm_out = '0, mtm_do = '0, mtm_di, gpf_do = '0, gpf_oe = '0, gpf_di;
  logic [19:0] sai_di = '0, acq_data;
  logic [3:0]  acq_ctl;
  logic [3:0]  fpin_di = '0, fpin_do, fpin_oe, cflag_do = '0, cflag_oe = '0, cflag_di;
  logic [2:0]  irq_req;

  pinmux_top u0 (.*);

  int    checks = 0, fails = 0;
  string phase = "R1 reset";

  // reference model state
  logic [31:0] m_sys = '0, m_acq = '0;
  logic        ev = 1'b0;
  logic [31:0] e_rd, e_do, e_oe, e_mdi;
  logic [3:0]  e_mtm, e_gpf, e_ctl, e_fdo, e_foe, e_cfd;
  logic [19:0] e_acq;
  logic [2:0]  e_irq;

  // 0 mem, 1 gpf, 2 mtm, 3 pwm, 4 acq
  function automatic int fn_of(int g);
    if (g >= 2 && m_sys[0] && m_acq[26] && m_acq[31]) return 4;
    if (g >= 4 && m_sys[8 + g])  return 3;
    if (g >= 4 && m_sys[16 + g]) return 2;
    if (m_sys[24 + g])           return 1;
    return 0;
  endfunction

  always @(posedge clk) begin
    ev <= 1'b1;
    if (rst) begin
      m_sys = '0; m_acq = '0;
      e_rd = '0; e_do = '0; e_oe = '0; e_mdi = '0; e_mtm = '0; e_gpf = '0;
      e_ctl = '0; e_acq = '0; e_fdo = '0; e_foe = '0; e_cfd = '0; e_irq = '0;
    end else begin
      bit take;
      bit mfound, gfound;
      take = m_sys[0] && m_acq[26] && m_acq[31];
      e_do = '0; e_oe = '0; e_mdi = '0; e_mtm = '0; e_gpf = '0;
      mfound = 0; gfound = 0;
      for (int i = 0; i < 32; i++) begin
        case (fn_of(i / 4))
          3: begin e_do[i] = pwm_out[i % 4]; e_oe[i] = 1'b1; end
          2: begin e_do[i] = mtm_do[i % 4];  e_oe[i] = mtm_oe; end
          1: begin e_do[i] = gpf_do[i % 4];  e_oe[i] = gpf_oe[i % 4]; end
          0: begin e_do[i] = mem_do[i]; e_oe[i] = mem_oe; e_mdi[i] = pad_di[i]; end
          default: ;
        endcase
      end
      for (int g = 0; g < 8; g++) begin
        if (fn_of(g) == 2 && !mfound) begin e_mtm = pad_di[g*4 +: 4]; mfound = 1; end
        if (fn_of(g) == 1 && !gfound) begin e_gpf = pad_di[g*4 +: 4]; gfound = 1; end
      end
      e_acq = take ? pad_di[31:12] : sai_di;
      e_ctl = take ? pad_di[11:8]  : 4'h0;
      for (int i = 0; i < 3; i++) begin
        if (m_sys[1 + i]) begin
          e_fdo[i] = 0; e_foe[i] = 0; e_cfd[i] = 0; e_irq[i] = fpin_di[i];
        end else begin
          e_fdo[i] = cflag_do[i]; e_foe[i] = cflag_oe[i]; e_cfd[i] = fpin_di[i]; e_irq[i] = 0;
        end
      end
      if (m_sys[4]) begin e_fdo[3] = tmr_exp; e_foe[3] = 1; e_cfd[3] = 0; end
      else begin e_fdo[3] = cflag_do[3]; e_foe[3] = cflag_oe[3]; e_cfd[3] = fpin_di[3]; end
      e_rd = cfg_sel ? m_acq : m_sys;
      if (cfg_wr && !cfg_sel) m_sys = cfg_wdata;
      if (cfg_wr &&  cfg_sel) m_acq = cfg_wdata;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s [%s] t=%0t actual %h expected %h", tag, phase, $time, act, exp);
    end
  endtask

  // compare every cycle, away from the active edge (R12 one-cycle latency)
  always @(negedge clk) if (ev) begin
    chk("R2 cfg_rdata", cfg_rdata, e_rd);
    chk("R9 pad_do", pad_do, e_do);
    chk("R9 pad_oe", pad_oe, e_oe);
    chk("R9 mem_di", mem_di, e_mdi);
    chk("R6 mtm_di", {28'h0, mtm_di}, {28'h0, e_mtm});
    chk("R7 gpf_di", {28'h0, gpf_di}, {28'h0, e_gpf});
    chk("R4 acq_data", {12'h0, acq_data}, {12'h0, e_acq});
    chk("R4 acq_ctl", {28'h0, acq_ctl}, {28'h0, e_ctl});
    chk("R10 fpin_do", {28'h0, fpin_do}, {28'h0, e_fdo});
    chk("R10 fpin_oe", {28'h0, fpin_oe}, {28'h0, e_foe});
    chk("R11 cflag_di", {28'h0, cflag_di}, {28'h0, e_cfd});
    chk("R10 irq_req", {29'h0, irq_req}, {29'h0, e_irq});
  end

  task automatic rand_in();
    pad_di  = $urandom(); mem_do = $urandom(); mem_oe = 1'($urandom());
    pwm_out = 4'($urandom()); mtm_do = 4'($urandom()); mtm_oe = 1'($urandom());
    gpf_do  = 4'($urandom()); gpf_oe = 4'($urandom()); sai_di = 20'($urandom());
    fpin_di = 4'($urandom()); cflag_do = 4'($urandom()); cflag_oe = 4'($urandom());
    tmr_exp = 1'($urandom());
  endtask

  task automatic run(int n);
    repeat (n) begin
      @(negedge clk);
      rand_in();
      cfg_sel = 1'($urandom());
    end
  endtask

  task automatic wr(logic sel, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d; rand_in();
    @(negedge clk);
    cfg_wr = 1'b0; rand_in();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    phase = "R1 defaults after reset";
    run(20);
    phase = "R2 write and readback";
    wr(1'b0, 32'h0000_00E0); wr(1'b1, 32'h0400_0000); run(10);
    wr(1'b0, 32'h0); run(10);
    phase = "R9 external memory mode";
    run(30);
    phase = "R5 pwm all groups, lower bits ignored";
    wr(1'b0, 32'h0000_FF00); run(20);
    phase = "R6 mtm all groups, lower bits ignored";
    wr(1'b0, 32'h00FF_0000); run(20);
    phase = "R7 flags on every group";
    wr(1'b0, 32'hFF00_0000); run(20);
    phase = "R7 flags on group 5 only";
    wr(1'b0, 32'h2000_0000); run(10);
    phase = "R8 priority pwm over mtm over flags";
    wr(1'b0, 32'hFF5A_A500); run(20);
    phase = "R3 select without enable stays on serial pins";
    wr(1'b0, 32'h0000_0001); wr(1'b1, 32'h0400_0000); run(15);
    phase = "R3 enable without select";
    wr(1'b1, 32'h8000_0000); run(10);
    phase = "R4 acquisition takes pins";
    wr(1'b1, 32'h8400_0000); run(20);
    phase = "R8 acquisition over all other modes";
    wr(1'b0, 32'hFFFF_FF01); run(20);
    phase = "R3 system bit cleared releases pins";
    wr(1'b0, 32'hFFFF_FF00); run(15);
    phase = "R10 irq mode on flag pins";
    wr(1'b0, 32'h0000_000E); run(20);
    phase = "R11 timer drives flag pin 3";
    wr(1'b0, 32'h0000_0010); run(20);
    phase = "R1 reset mid-run";
    wr(1'b0, 32'hFFFF_FFFF);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    run(10);
    phase = "R12 random configuration";
    repeat (3000) begin
      if ($urandom_range(0, 15) == 0) begin
        logic [31:0] d;
        d = $urandom();
        if ($urandom_range(0, 1) == 1) d = d | 32'h8400_0001;
        wr(1'($urandom()), d);
      end else run(1);
    end
    run(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule